// File: doc/BRIEF.md
# Sideband Deep-Sleep Link Power Controller

This block sits on the device side of a serial storage link. It watches an asynchronous sleep request pin driven by the host and turns it into a clean power state for the link. While the request is held and the host has enabled the feature, the block removes power from the PHY, the PLL and a chosen set of auxiliary power domains. In that state it keeps the device from transmitting and disregards every out-of-band event the PHY front end reports.

When the host drops the pin, the block powers the PHY and PLL back up. It raises an out-of-band-ready output once the PLL reports lock, and then restores the remaining domains. A cycle counter compares the wake-up time with a configurable window, which defaults to 20 ms at 50 MHz, and raises a status flag if the window is exceeded. The link then leaves the ready state on either a wake sequence or a reset sequence from the host. Both return the device to normal operation through a link bring-up pulse, and a reset sequence also pulses an interface reset.

A request that arrives while the feature is disabled produces no power change. It only raises a status bit, which stays set until the request is withdrawn.

Top module: `link_deep_sleep`

## Requirements
- R1: Synchronous active-low reset puts the block in the normal state. In that state phy_pwr_en_o, pll_en_o, oob_ready_o and phy_tx_allow_o are 1, aux_pwr_en_o is all ones, and in_sleep_o, link_bringup_o, if_reset_o, exit_late_o and sleep_reject_o are 0.
- R2: sleep_pin_i passes through a two-stage synchroniser and then a filter. The filter changes its output only after 4 consecutive equal samples that differ from the current output. A pin pulse of 3 clocks never causes sleep, and a pulse of 4 clocks does.
- R3: While the filtered pin is high and entry was allowed, in_sleep_o is 1 and phy_pwr_en_o, pll_en_o, phy_tx_allow_o and oob_ready_o are 0. The aux bits selected by AUX_SLEEP_MASK are 0; with the default mask 3'b101 over 3 domains, aux_pwr_en_o reads 3'b010.
- R4: In sleep, oob_wake_i, oob_reset_i and pll_lock_i have no effect. The block stays asleep and emits no link_bringup_o or if_reset_o pulse.
- R5: If the filtered pin rises while feat_en_i is 0, sleep_reject_o goes to 1 and no sleep happens. This holds even if feat_en_i becomes 1 during the same assertion. sleep_reject_o returns to 0 once the filtered pin is low.
- R6: After the filtered pin falls, phy_pwr_en_o and pll_en_o return to 1 at once. oob_ready_o rises one clock after pll_lock_i is seen high, and the masked aux domains come back together with oob_ready_o. phy_tx_allow_o stays 0 until a wake or reset sequence arrives.
- R7: The exit window is exit_limit_i cycles, or DEF_EXIT_CYC (1,000,000) when exit_limit_i is 0. exit_late_o goes to 1 if the wake-up phase lasts more than the window. It stays 1 until the next sleep entry.
- R8: In the ready state, oob_wake_i gives one single-cycle link_bringup_o pulse without if_reset_o and returns the block to normal with phy_tx_allow_o = 1.
- R9: In the ready state, oob_reset_i gives one single-cycle pulse on both link_bringup_o and if_reset_o. When oob_wake_i and oob_reset_i arrive in the same cycle, the reset treatment wins.
- R10: If the filtered pin rises again during wake-up or ready while the feature is enabled, the block returns straight to sleep.
- R11: oob_wake_i and oob_reset_i in the normal state produce no pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sleep_pin_i | input | 1 | Asynchronous sleep request from the host |
| feat_en_i | input | 1 | Host has enabled the sleep feature |
| exit_limit_i | input | LIMIT_W | Exit window in cycles; 0 selects the default |
| pll_lock_i | input | 1 | PLL lock indication |
| oob_wake_i | input | 1 | Wake sequence detected |
| oob_reset_i | input | 1 | Reset sequence detected |
| phy_pwr_en_o | output | 1 | PHY power enable |
| pll_en_o | output | 1 | PLL enable |
| aux_pwr_en_o | output | N_AUX | Auxiliary domain power enables |
| phy_tx_allow_o | output | 1 | Device may start PHY traffic |
| oob_ready_o | output | 1 | Out-of-band detection available |
| in_sleep_o | output | 1 | Deep-sleep state active |
| link_bringup_o | output | 1 | One-cycle pulse that starts link bring-up |
| if_reset_o | output | 1 | One-cycle interface reset pulse |
| exit_late_o | output | 1 | Wake-up exceeded the exit window |
| sleep_reject_o | output | 1 | Request seen while the feature was disabled |

## Verification
Two of the block's functions can coincide in one clock. The wake and reset sequences can both arrive in the ready state in the same cycle, and a renewed sleep request can meet a ready-state event. The bench drives oob_wake_i and oob_reset_i together in a single cycle after a full sleep and exit. It then expects both link_bringup_o and if_reset_o high in the next sample and both low in the one after. It also re-raises the pin during wake-up and ready, and expects a return to sleep with no pulse.

// File: rtl/slp_pkg.sv
// Package: shared types for the deep-sleep link power controller.
// Assumes: nothing beyond a 2-bit state encoding.
package slp_pkg;
    typedef enum logic [1:0] {
        ST_ACTIVE = 2'd0,   // link powered, device may transmit
        ST_SLEEP  = 2'd1,   // PHY, PLL and masked domains off
        ST_WAKEUP = 2'd2,   // power restored, waiting for PLL lock
        ST_READY  = 2'd3    // OOB detection live, waiting for host sequence
    } slp_state_e;
endpackage

// File: rtl/slp_pin_filter.sv
// slp_pin_filter: brings the asynchronous sleep pin into the clock domain
// through a synchroniser chain, then holds its output until the
// synchronised level has differed from it for FILT_LEN consecutive samples.
// Assumes: SYNC_STAGES >= 2, FILT_LEN >= 2.
module slp_pin_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic filt_o
);
    localparam int CNT_W = $clog2(FILT_LEN + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FILT_LEN - 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CNT_W-1:0]       cnt_q;
    logic                   filt_q;
    logic                   sync_lvl;

    assign sync_lvl = sync_q[SYNC_STAGES-1];

    // Shift the raw pin through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
    end

    // Count consecutive disagreeing samples and flip the output on the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            filt_q <= 1'b0;
        end else if (sync_lvl == filt_q) begin
            cnt_q <= '0;
        end else if (cnt_q == CNT_LAST) begin
            cnt_q  <= '0;
            filt_q <= sync_lvl;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign filt_o = filt_q;

    // A filtered change needs at least two equal synchronised samples before it.
    assert_filter_settled_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (filt_q != $past(filt_q)) |-> ($past(sync_lvl) == $past(sync_lvl, 2)));
endmodule

// File: rtl/slp_exit_timer.sv
// slp_exit_timer: counts the cycles spent in the wake-up phase and flags
// when they exceed the exit window (the configured value, or DEF_LIMIT if it is 0).
// Assumes: run_i is high only in the wake-up phase; clear_i pulses on sleep entry.
module slp_exit_timer #(
    parameter int LIMIT_W   = 20,
    parameter int DEF_LIMIT = 1_000_000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run_i,
    input  logic               clear_i,
    input  logic [LIMIT_W-1:0] limit_i,
    output logic               late_o
);
    localparam logic [LIMIT_W-1:0] DEF_VAL = LIMIT_W'(DEF_LIMIT);
    localparam logic [LIMIT_W-1:0] CNT_MAX = '1;

    logic [LIMIT_W-1:0] cnt_q;
    logic [LIMIT_W-1:0] eff_limit;
    logic               late_q;

    // Select the configured window, falling back to the default.
    always_comb begin
        eff_limit = (limit_i == '0) ? DEF_VAL : limit_i;
    end

    // Saturating wake-up cycle counter, cleared outside the wake-up phase.
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt_q <= '0;
        else if (!run_i)        cnt_q <= '0;
        else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end

    // Sticky overrun flag, cleared when the next sleep begins.
    always_ff @(posedge clk) begin
        if (!rst_n)                           late_q <= 1'b0;
        else if (clear_i)                     late_q <= 1'b0;
        else if (run_i && cnt_q == eff_limit) late_q <= 1'b1;
    end

    assign late_o = late_q;

    // The flag may only rise while the wake-up phase is running.
    assert_late_in_wakeup_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(late_q) |-> $past(run_i));
    // A sleep entry always leaves the flag low.
    assert_late_cleared_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> !late_q);
endmodule

// File: rtl/slp_fsm.sv
// slp_fsm: link power state machine. It enters sleep on an accepted request,
// waits in wake-up for PLL lock, then waits in ready for a host wake or
// reset sequence and issues the registered bring-up and reset pulses.
// Assumes: filt_i is already synchronous and deglitched.
module slp_fsm
    import slp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       filt_i,
    input  logic       feat_en_i,
    input  logic       pll_lock_i,
    input  logic       oob_wake_i,
    input  logic       oob_reset_i,
    output slp_state_e state_o,
    output logic       enter_o,
    output logic       reject_o,
    output logic       bringup_o,
    output logic       ifrst_o
);
    slp_state_e state_q, state_d;
    logic       reject_q, reject_d;
    logic       bringup_q, ifrst_q;
    logic       sleep_req;
    logic       ready_evt;

    assign sleep_req = filt_i && feat_en_i && !reject_q;
    assign ready_evt = (state_q == ST_READY) && !sleep_req && (oob_wake_i || oob_reset_i);

    // Next-state selection; a fresh request outranks any ready-state event.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ACTIVE: if (sleep_req) state_d = ST_SLEEP;
            ST_SLEEP:  if (!filt_i)   state_d = ST_WAKEUP;
            ST_WAKEUP: begin
                if (sleep_req)       state_d = ST_SLEEP;
                else if (pll_lock_i) state_d = ST_READY;
            end
            ST_READY: begin
                if (sleep_req)      state_d = ST_SLEEP;
                else if (ready_evt) state_d = ST_ACTIVE;
            end
            default: state_d = ST_ACTIVE;
        endcase
    end

    // The reject latch sets on a disabled request and holds until the pin falls.
    always_comb begin
        reject_d = filt_i && (reject_q || (state_q != ST_SLEEP && !feat_en_i));
    end

    // State, reject latch and event pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_ACTIVE;
            reject_q  <= 1'b0;
            bringup_q <= 1'b0;
            ifrst_q   <= 1'b0;
        end else begin
            state_q   <= state_d;
            reject_q  <= reject_d;
            bringup_q <= ready_evt;
            ifrst_q   <= ready_evt && oob_reset_i;
        end
    end

    assign state_o   = state_q;
    assign enter_o   = (state_d == ST_SLEEP) && (state_q != ST_SLEEP);
    assign reject_o  = reject_q;
    assign bringup_o = bringup_q;
    assign ifrst_o   = ifrst_q;

    // Sleep is entered only when the feature was enabled.
    assert_entry_enabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SLEEP && $past(state_q) != ST_SLEEP) |-> $past(feat_en_i));
    // Sleep persists while the filtered request stays high.
    assert_sleep_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SLEEP && filt_i) |=> (state_q == ST_SLEEP));
    // No pulse leaves the block while it sleeps.
    assert_quiet_in_sleep_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SLEEP) |-> (!bringup_q && !ifrst_q));
    // Ready is reached only after lock was observed.
    assert_ready_after_lock_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_READY && $past(state_q) == ST_WAKEUP) |-> $past(pll_lock_i));
    // Bring-up is a single-cycle pulse.
    assert_bringup_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bringup_q |=> !bringup_q);
    // An interface reset always comes with a bring-up.
    assert_ifrst_pairs_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ifrst_q |-> bringup_q);
    // Pulses only follow the ready state.
    assert_pulse_from_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
        bringup_q |-> ($past(state_q) == ST_READY));
endmodule

// File: rtl/link_deep_sleep.sv
// link_deep_sleep: top of the device-side sideband deep-sleep controller.
// Filters the host sleep pin, runs the power state machine, times the exit
// window and drives PHY, PLL and auxiliary power enables.
// Assumes: pll_lock_i, oob_wake_i and oob_reset_i are synchronous to clk.
module link_deep_sleep
    import slp_pkg::*;
#(
    parameter int               SYNC_STAGES    = 2,
    parameter int               FILT_LEN       = 4,
    parameter int               LIMIT_W        = 20,
    parameter int               DEF_EXIT_CYC   = 1_000_000,
    parameter int               N_AUX          = 3,
    parameter logic [N_AUX-1:0] AUX_SLEEP_MASK = 3'b101
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sleep_pin_i,
    input  logic               feat_en_i,
    input  logic [LIMIT_W-1:0] exit_limit_i,
    input  logic               pll_lock_i,
    input  logic               oob_wake_i,
    input  logic               oob_reset_i,
    output logic               phy_pwr_en_o,
    output logic               pll_en_o,
    output logic [N_AUX-1:0]   aux_pwr_en_o,
    output logic               phy_tx_allow_o,
    output logic               oob_ready_o,
    output logic               in_sleep_o,
    output logic               link_bringup_o,
    output logic               if_reset_o,
    output logic               exit_late_o,
    output logic               sleep_reject_o
);
    logic       pin_filt;
    slp_state_e state;
    logic       enter_sleep;
    logic       full_power;

    slp_pin_filter #(
        .SYNC_STAGES (SYNC_STAGES),
        .FILT_LEN    (FILT_LEN)
    ) u_filter (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (sleep_pin_i),
        .filt_o (pin_filt)
    );

    slp_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .filt_i      (pin_filt),
        .feat_en_i   (feat_en_i),
        .pll_lock_i  (pll_lock_i),
        .oob_wake_i  (oob_wake_i),
        .oob_reset_i (oob_reset_i),
        .state_o     (state),
        .enter_o     (enter_sleep),
        .reject_o    (sleep_reject_o),
        .bringup_o   (link_bringup_o),
        .ifrst_o     (if_reset_o)
    );

    slp_exit_timer #(
        .LIMIT_W   (LIMIT_W),
        .DEF_LIMIT (DEF_EXIT_CYC)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (state == ST_WAKEUP),
        .clear_i (enter_sleep),
        .limit_i (exit_limit_i),
        .late_o  (exit_late_o)
    );

    // Decode the power and status outputs from the state.
    always_comb begin
        full_power     = (state == ST_READY) || (state == ST_ACTIVE);
        in_sleep_o     = (state == ST_SLEEP);
        phy_pwr_en_o   = (state != ST_SLEEP);
        pll_en_o       = (state != ST_SLEEP);
        oob_ready_o    = full_power;
        phy_tx_allow_o = (state == ST_ACTIVE);
    end

    // Per domain: masked domains follow full power, the rest stay on.
    for (genvar g = 0; g < N_AUX; g++) begin : g_aux
        if (AUX_SLEEP_MASK[g]) begin : g_gated
            assign aux_pwr_en_o[g] = full_power;
        end else begin : g_always
            assign aux_pwr_en_o[g] = 1'b1;
        end
    end

    // The device never gets permission to transmit straight out of sleep.
    assert_no_tx_after_sleep_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(in_sleep_o) |-> !phy_tx_allow_o);
endmodule

// File: tb/tb_link_deep_sleep.sv
module tb_link_deep_sleep;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sleep_pin = 1'b0;
    logic        feat_en = 1'b1;
    logic [19:0] exit_limit = '0;
    logic        pll_lock = 1'b1;
    logic        oob_wake = 1'b0;
    logic        oob_reset = 1'b0;
    logic        phy_pwr_en, pll_en, phy_tx_allow, oob_ready, in_sleep;
    logic        link_bringup, if_reset, exit_late, sleep_reject;
    logic [2:0]  aux_pwr_en;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    always #10 clk = ~clk; // 50 MHz

    link_deep_sleep dut (
        .clk(clk), .rst_n(rst_n), .sleep_pin_i(sleep_pin), .feat_en_i(feat_en),
        .exit_limit_i(exit_limit), .pll_lock_i(pll_lock), .oob_wake_i(oob_wake),
        .oob_reset_i(oob_reset), .phy_pwr_en_o(phy_pwr_en), .pll_en_o(pll_en),
        .aux_pwr_en_o(aux_pwr_en), .phy_tx_allow_o(phy_tx_allow),
        .oob_ready_o(oob_ready), .in_sleep_o(in_sleep), .link_bringup_o(link_bringup),
        .if_reset_o(if_reset), .exit_late_o(exit_late), .sleep_reject_o(sleep_reject)
    );

    // Watchdog: an expired run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 100000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: run did not finish (actual %0d cycles, expected < 100000)", cyc);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Vector: [15] pin, [14] feat, [13] lock, [12:8] hold, [7:4] requirement,
    //         [3] in_sleep, [2] oob_ready, [1] phy_pwr_en, [0] sleep_reject
    localparam int NV = 12;
    localparam logic [15:0] VEC [NV] = '{
        {1'b0, 1'b1, 1'b1, 5'd4,  4'd1,  4'b0110},
        {1'b1, 1'b1, 1'b0, 5'd12, 4'd3,  4'b1000},
        {1'b1, 1'b1, 1'b1, 5'd6,  4'd4,  4'b1000},
        {1'b0, 1'b1, 1'b0, 5'd12, 4'd6,  4'b0010},
        {1'b0, 1'b1, 1'b1, 5'd3,  4'd6,  4'b0110},
        {1'b1, 1'b0, 1'b1, 5'd12, 4'd5,  4'b0111},
        {1'b1, 1'b1, 1'b1, 5'd6,  4'd5,  4'b0111},
        {1'b0, 1'b1, 1'b1, 5'd12, 4'd5,  4'b0110},
        {1'b1, 1'b1, 1'b0, 5'd12, 4'd10, 4'b1000},
        {1'b0, 1'b1, 1'b0, 5'd12, 4'd6,  4'b0010},
        {1'b1, 1'b1, 1'b0, 5'd12, 4'd10, 4'b1000},
        {1'b0, 1'b1, 1'b1, 5'd12, 4'd6,  4'b0110}
    };

    // Enter sleep, then exit with the given lock level and wait for the outcome.
    task automatic sleep_and_exit(input logic lock_at_exit);
        sleep_pin = 1'b1;
        repeat (12) tick();
        pll_lock  = lock_at_exit;
        sleep_pin = 1'b0;
        repeat (12) tick();
    endtask

    initial begin
        logic seen;
        string rq;
        repeat (3) tick();
        // R1: reset state
        chk("R1", "in_sleep", 32'(in_sleep), 0);
        chk("R1", "phy_pwr_en", 32'(phy_pwr_en), 1);
        chk("R1", "pll_en", 32'(pll_en), 1);
        chk("R1", "oob_ready", 32'(oob_ready), 1);
        chk("R1", "phy_tx_allow", 32'(phy_tx_allow), 1);
        chk("R1", "aux_pwr_en", 32'(aux_pwr_en), 32'h7);
        chk("R1", "pulses", 32'({link_bringup, if_reset}), 0);
        chk("R1", "status", 32'({exit_late, sleep_reject}), 0);
        rst_n = 1'b1;
        tick();

        // Vector walk: R3, R4, R5, R6, R10 state sequence
        for (int i = 0; i < NV; i++) begin
            sleep_pin = VEC[i][15];
            feat_en   = VEC[i][14];
            pll_lock  = VEC[i][13];
            repeat (int'(VEC[i][12:8])) tick();
            rq = $sformatf("R%0d", VEC[i][7:4]);
            chk(rq, $sformatf("vec%0d in_sleep", i), 32'(in_sleep), 32'(VEC[i][3]));
            chk(rq, $sformatf("vec%0d oob_ready", i), 32'(oob_ready), 32'(VEC[i][2]));
            chk(rq, $sformatf("vec%0d phy_pwr_en", i), 32'(phy_pwr_en), 32'(VEC[i][1]));
            chk(rq, $sformatf("vec%0d sleep_reject", i), 32'(sleep_reject), 32'(VEC[i][0]));
        end

        // R8: wake sequence in ready gives a single bring-up pulse, no reset
        oob_wake = 1'b1; tick();
        chk("R8", "link_bringup", 32'(link_bringup), 1);
        chk("R8", "if_reset", 32'(if_reset), 0);
        chk("R8", "phy_tx_allow", 32'(phy_tx_allow), 1);
        oob_wake = 1'b0; tick();
        chk("R8", "link_bringup after", 32'(link_bringup), 0);

        // R11: sequences in the normal state are ignored
        oob_wake = 1'b1; oob_reset = 1'b1; tick();
        chk("R11", "pulses in active", 32'({link_bringup, if_reset}), 0);
        oob_wake = 1'b0; oob_reset = 1'b0; tick();
        chk("R11", "phy_tx_allow", 32'(phy_tx_allow), 1);

        // R2: a 3-clock glitch never causes sleep
        sleep_pin = 1'b1; repeat (3) tick(); sleep_pin = 1'b0;
        seen = 1'b0;
        repeat (12) begin tick(); seen |= in_sleep; end
        chk("R2", "sleep after 3-clock pulse", 32'(seen), 0);
        // R2: a 4-clock pulse does cause sleep
        sleep_pin = 1'b1; repeat (4) tick(); sleep_pin = 1'b0;
        seen = 1'b0;
        repeat (12) begin tick(); seen |= in_sleep; end
        chk("R2", "sleep after 4-clock pulse", 32'(seen), 1);
        oob_wake = 1'b1; tick(); oob_wake = 1'b0; tick();

        // R4: OOB and lock inputs ignored in sleep; R3: power view in sleep
        sleep_pin = 1'b1; pll_lock = 1'b0;
        repeat (12) tick();
        chk("R3", "aux_pwr_en in sleep", 32'(aux_pwr_en), 32'h2);
        chk("R3", "pll_en in sleep", 32'(pll_en), 0);
        chk("R3", "phy_tx_allow in sleep", 32'(phy_tx_allow), 0);
        oob_wake = 1'b1; oob_reset = 1'b1; pll_lock = 1'b1;
        seen = 1'b0;
        repeat (5) begin tick(); seen |= link_bringup | if_reset; end
        chk("R4", "pulses in sleep", 32'(seen), 0);
        chk("R4", "still asleep", 32'(in_sleep), 1);
        oob_wake = 1'b0; oob_reset = 1'b0; pll_lock = 1'b0;

        // R6: staged power-up
        sleep_pin = 1'b0;
        repeat (12) tick();
        chk("R6", "pll_en in wakeup", 32'(pll_en), 1);
        chk("R6", "aux_pwr_en in wakeup", 32'(aux_pwr_en), 32'h2);
        chk("R6", "oob_ready before lock", 32'(oob_ready), 0);
        pll_lock = 1'b1; tick();
        chk("R6", "oob_ready after lock", 32'(oob_ready), 1);
        chk("R6", "aux_pwr_en after lock", 32'(aux_pwr_en), 32'h7);
        chk("R6", "phy_tx_allow in ready", 32'(phy_tx_allow), 0);

        // R9: reset sequence pulses both outputs
        oob_reset = 1'b1; tick();
        chk("R9", "if_reset", 32'(if_reset), 1);
        chk("R9", "link_bringup", 32'(link_bringup), 1);
        oob_reset = 1'b0; tick();
        chk("R9", "if_reset after", 32'(if_reset), 0);
        chk("R9", "phy_tx_allow", 32'(phy_tx_allow), 1);

        // R9: wake and reset in the same cycle take the reset treatment
        sleep_and_exit(1'b1);
        oob_wake = 1'b1; oob_reset = 1'b1; tick();
        chk("R9", "coincident if_reset", 32'(if_reset), 1);
        chk("R9", "coincident link_bringup", 32'(link_bringup), 1);
        oob_wake = 1'b0; oob_reset = 1'b0; tick();
        chk("R9", "coincident pulses end", 32'({link_bringup, if_reset}), 0);

        // R7: overrun with a short configured window
        exit_limit = 20'd8;
        sleep_pin = 1'b1; repeat (12) tick();
        pll_lock = 1'b0; sleep_pin = 1'b0;
        repeat (30) tick();
        chk("R7", "exit_late short window", 32'(exit_late), 1);
        pll_lock = 1'b1; tick();
        chk("R7", "oob_ready late lock", 32'(oob_ready), 1);
        chk("R7", "exit_late sticky", 32'(exit_late), 1);
        sleep_pin = 1'b1; repeat (12) tick();
        chk("R7", "exit_late cleared on entry", 32'(exit_late), 0);
        sleep_pin = 1'b0; repeat (12) tick();
        chk("R7", "exit_late with fast lock", 32'(exit_late), 0);
        // R7: default window is not exceeded by a 30-cycle wait
        exit_limit = '0;
        sleep_pin = 1'b1; repeat (12) tick();
        pll_lock = 1'b0; sleep_pin = 1'b0;
        repeat (30) tick();
        chk("R7", "exit_late default window", 32'(exit_late), 0);
        pll_lock = 1'b1; tick();

        // R1: reset during sleep returns to the normal state
        sleep_pin = 1'b1; repeat (12) tick();
        rst_n = 1'b0; tick();
        chk("R1", "in_sleep under reset", 32'(in_sleep), 0);
        chk("R1", "phy_tx_allow under reset", 32'(phy_tx_allow), 1);
        sleep_pin = 1'b0; tick();
        rst_n = 1'b1; repeat (12) tick();
        chk("R1", "stays normal after reset", 32'(in_sleep), 0);

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule